// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Shared-Access Handshake

This block fetches a run of 16-bit words from a three-wire serial EEPROM (the Microwire read protocol) for a host. The host presents a start word address, a word count, a handshake-enable flag and a size flag, then pulses `start`. The block reads the words one after another and hands each one back on `word_data` with a one-cycle `word_valid` strobe. When the last word has gone out, it ends the run with a one-cycle `done` pulse.

Each word is a transaction of its own. The block first parks clock and data low, then raises chip select. It shifts out the 3-bit read opcode `110` and then the address, both most significant bit first. After that it clocks in 16 data bits, most significant bit first. Chip select then drops and stays low for one bit period. Bit timing comes from the `CLK_MHZ` parameter: a bit period of 2 µs is `2*CLK_MHZ` cycles, and a grant poll interval of 5 µs is `5*CLK_MHZ` cycles.

Another agent may share the EEPROM. In handshake mode the block therefore raises `req` before every word and waits for `gnt` before it touches the serial pins. It samples `gnt` up to `POLL_TRIES` times, one poll interval apart. If no grant arrives, the block drops the request, returns `16'hFFFF` for that word and moves on to the next word.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is asserted, `ee_cs`, `ee_sk`, `ee_di`, `req`, `busy`, `done` and `word_valid` are all low.
- R2: Every word transaction clocks out the bits `1`,`1`,`0` on `ee_di` (one per rising edge of `ee_sk`). It then clocks out the address MSB first, followed by exactly 16 data clocks, all while `ee_cs` is high.
- R3: The address field is 6 bits when `size_big` was 0 at `start` and 8 bits when it was 1. A frame therefore has 25 or 27 rising edges of `ee_sk`.
- R4: The address sent for the i-th word of a run (counting from 0) is `base_addr + i`, reduced modulo 2^6 or 2^8 to match the address width.
- R5: Each data bit is sampled from `ee_do` while `ee_sk` is high, and the first bit sampled is the word's MSB. Words appear on `word_data` with a one-cycle `word_valid`, in address order, one per requested word.
- R6: Before every rising edge of `ee_sk`, `ee_di` has held its value for at least one bit period. `ee_sk` stays high for at least one bit period, `ee_di` does not change while `ee_sk` is high, and `ee_di` is low during the 16 data clocks.
- R7: `ee_sk` is high only while `ee_cs` is high. `ee_cs` rises while `ee_sk` is low, and only after `ee_cs` has been low for at least one bit period.
- R8: In handshake mode, `ee_cs` is high only while `req` is high, and a frame starts only after `gnt` has been seen high.
- R9: In handshake mode, if `gnt` is not seen in `POLL_TRIES` samples taken `5*CLK_MHZ` cycles apart, `req` falls after no more than `POLL_TRIES*5*CLK_MHZ` cycles. The serial pins stay idle, the word is reported as `16'hFFFF`, and the run continues.
- R10: After a completed frame, `req` falls only once `ee_cs` has been low for at least one bit period.
- R11: With handshake mode off, `req` stays low.
- R12: `busy` is high from the cycle after an accepted `start` until the cycle `done` pulses, and `done` lasts one cycle. A `start` while busy is ignored. A word count of 0 ends the run with no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| base_addr | input | 8 | Word address of the first word |
| word_cnt | input | CNT_W | Number of words to read |
| hs_en | input | 1 | Acquire the EEPROM through req/gnt before each word |
| size_big | input | 1 | 1 selects 8 address bits, 0 selects 6 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| word_valid | output | 1 | One-cycle strobe: word_data holds a new word |
| word_data | output | 16 | Word read, or 16'hFFFF after a grant timeout |
| req | output | 1 | Access request to the external arbiter |
| gnt | input | 1 | Access grant from the external arbiter |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data into the device |
| ee_do | input | 1 | EEPROM serial data out of the device |

## Verification
The bench models the EEPROM behaviourally and decodes every frame from the pins. Runs use both address widths with plain start addresses and start addresses that wrap at 2^6 and 2^8. This separates a correct width and increment from an off-by-one count or a missing wrap. Four grant cases are tried: handshake off, grant already high, a grant that arrives late, and a grant that never comes. Together they separate waiting from skipping the wait, and timeout substitution from a hang. A `start` pulsed mid-run and a zero word count probe the host handshake edges.

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int CLK_MHZ    = 200,
  parameter int POLL_TRIES = 100,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       base_addr,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic             hs_en,
  input  logic             size_big,
  output logic             busy,
  output logic             done,
  output logic             word_valid,
  output logic [15:0]      word_data,
  output logic             req,
  input  logic             gnt,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);
  localparam int BIT_CYC  = 2 * CLK_MHZ;
  localparam int POLL_CYC = 5 * CLK_MHZ;
  localparam int TMR_W    = $clog2(POLL_CYC + 1);
  localparam int TRY_W    = $clog2(POLL_TRIES + 1);
  localparam logic [TMR_W-1:0] TMR_BIT  = TMR_W'(BIT_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_POLL = TMR_W'(POLL_CYC - 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_TRIES - 1);

  typedef enum logic [2:0] {IDLE, LAUNCH, ACQ, PRE, CSUP, LO, HI, CSOFF} st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [TRY_W-1:0] tries;
  logic [7:0]       addr_q;
  logic [CNT_W-1:0] left;
  logic             hs_q, big_q;
  logic [26:0]      sh;
  logic [4:0]       bits;
  logic [15:0]      rx;

  wire        tmr_done   = (tmr == '0);
  wire [26:0] frame_init = big_q ? {3'b110, addr_q, 16'h0000}
                                 : {3'b110, addr_q[5:0], 18'h00000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tmr <= '0; tries <= '0; addr_q <= '0; left <= '0;
      hs_q <= 1'b0; big_q <= 1'b0; sh <= '0; bits <= '0; rx <= '0;
      busy <= 1'b0; done <= 1'b0; word_valid <= 1'b0; word_data <= '0;
      req <= 1'b0; ee_cs <= 1'b0; ee_sk <= 1'b0; ee_di <= 1'b0;
    end else begin
      done       <= 1'b0;
      word_valid <= 1'b0;
      if (!tmr_done) tmr <= tmr - 1'b1;
      case (st)
        IDLE: if (start) begin
          busy <= 1'b1; addr_q <= base_addr; left <= word_cnt;
          hs_q <= hs_en; big_q <= size_big; st <= LAUNCH;
        end
        LAUNCH: if (left == '0) begin
          busy <= 1'b0; done <= 1'b1; st <= IDLE;
        end else begin
          left <= left - 1'b1;
          sh   <= frame_init;
          bits <= big_q ? 5'd27 : 5'd25;
          if (hs_q) begin
            req <= 1'b1; tmr <= '0; tries <= '0; st <= ACQ;
          end else begin
            tmr <= TMR_BIT; st <= PRE;
          end
        end
        ACQ: if (tmr_done) begin
          if (gnt) begin
            tmr <= TMR_BIT; st <= PRE;
          end else if (tries == TRY_LAST) begin
            req <= 1'b0; word_data <= 16'hFFFF; word_valid <= 1'b1;
            addr_q <= addr_q + 8'd1; st <= LAUNCH;
          end else begin
            tries <= tries + 1'b1; tmr <= TMR_POLL;
          end
        end
        PRE: if (tmr_done) begin
          ee_cs <= 1'b1; tmr <= TMR_BIT; st <= CSUP;
        end
        CSUP: if (tmr_done) begin
          ee_di <= sh[26]; tmr <= TMR_BIT; st <= LO;
        end
        LO: if (tmr_done) begin
          ee_sk <= 1'b1; tmr <= TMR_BIT; st <= HI;
        end
        HI: if (tmr_done) begin
          ee_sk <= 1'b0;
          if (bits <= 5'd16) rx <= {rx[14:0], ee_do};
          sh   <= sh << 1;
          bits <= bits - 5'd1;
          tmr  <= TMR_BIT;
          if (bits == 5'd1) begin
            ee_cs <= 1'b0; ee_di <= 1'b0; st <= CSOFF;
          end else begin
            ee_di <= sh[25]; st <= LO;
          end
        end
        CSOFF: if (tmr_done) begin
          req <= 1'b0; word_data <= rx; word_valid <= 1'b1;
          addr_q <= addr_q + 8'd1; st <= LAUNCH;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic req,
  input logic busy,
  input logic done,
  input logic word_valid,
  input logic hs_q
);
  // R7
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs);
  // R7
  cs_rise_sk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> !ee_sk);
  // R6
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  // R8
  cs_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (ee_cs && hs_q) |-> req);
  // R11
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !hs_q) |-> !req);
  // R10
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(req) |-> !ee_cs);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !word_valid));
  // R5
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> busy);
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .req(req), .busy(busy), .done(done), .word_valid(word_valid), .hs_q(hs_q)
);

// File: tb/tb_mw_eeprom_reader.sv
`timescale 1ns/1ps
module tb_mw_eeprom_reader;
  localparam int MHZ = 2, BIT = 2 * MHZ, POLL = 5 * MHZ, TRIES = 100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, hs_en = 1'b0, size_big = 1'b0;
  logic [7:0] base_addr = '0, word_cnt = '0;
  logic busy, done, word_valid, req, ee_cs, ee_sk, ee_di;
  logic [15:0] word_data;
  logic gnt = 1'b0, ee_do = 1'b0;

  mw_eeprom_reader #(.CLK_MHZ(MHZ), .POLL_TRIES(TRIES), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .word_cnt(word_cnt),
    .hs_en(hs_en), .size_big(size_big), .busy(busy), .done(done), .word_valid(word_valid),
    .word_data(word_data), .req(req), .gnt(gnt), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, got = 0;
  bit finished = 0, timed_out = 0;
  int gmode = 0, gdelay = 0;
  bit cur_hs = 0, cur_big = 0;
  logic [15:0] expw[$];
  logic [7:0]  expa[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] memf(input logic [7:0] a);
    return 16'(a * 257) ^ 16'h5AC3;
  endfunction

  logic psk = 0, pcs = 0, pdi = 0, preq = 0;
  int di_age = 0, sk_hi = 0, cs_lo_age = 0, req_age = 0, bitpos = 0, wbits, k;
  logic [2:0] opc = '0;
  logic [7:0] radr = '0, ea;
  logic [15:0] rword = '0, ew;

  always @(negedge clk) if (rst_n) begin
    wbits = cur_big ? 8 : 6;
    if (!cur_hs) chk(req == 1'b0, "R11", "req with handshake off", req, 0);
    if (gmode == 2) chk(ee_cs == 1'b0, "R9", "cs during timeout", ee_cs, 0);
    di_age = (ee_di != pdi) ? 0 : di_age + 1;
    if (ee_sk && !psk) begin
      chk(ee_cs, "R7", "sk rise without cs", ee_cs, 1);
      chk(di_age >= BIT, "R6", "di setup cycles", di_age, BIT);
      if (bitpos < 3) opc = {opc[1:0], ee_di};
      else if (bitpos < 3 + wbits) radr = {radr[6:0], ee_di};
      else begin
        chk(ee_di == 1'b0, "R6", "di in data phase", ee_di, 0);
        k = bitpos - 3 - wbits;
        if (k == 0) rword = memf(cur_big ? radr : {2'b00, radr[5:0]});
        if (k < 16) ee_do = rword[15 - k];
      end
      bitpos++;
    end
    if (!ee_sk && psk) chk(sk_hi >= BIT, "R6", "sk high cycles", sk_hi, BIT);
    sk_hi = ee_sk ? sk_hi + 1 : 0;
    if (ee_cs && !pcs) begin
      chk(cs_lo_age >= BIT, "R7", "cs low gap", cs_lo_age, BIT);
      chk(!ee_sk, "R7", "sk at cs rise", ee_sk, 0);
      if (cur_hs) chk(req && gnt, "R8", "frame without grant", {req, gnt}, 3);
      bitpos = 0; opc = '0; radr = '0;
    end
    if (!ee_cs && pcs) begin
      chk(bitpos == 19 + wbits, "R3", "clocks per frame", bitpos, 19 + wbits);
      chk(opc == 3'b110, "R2", "opcode", opc, 6);
      ea = (expa.size() != 0) ? expa.pop_front() : 8'hxx;
      chk((cur_big ? radr : {2'b00, radr[5:0]}) == ea, "R4", "frame address", radr, ea);
    end
    cs_lo_age = ee_cs ? 0 : cs_lo_age + 1;
    if (!req && preq) begin
      if (gmode == 2)
        chk(req_age >= (TRIES - 1) * POLL && req_age <= TRIES * POLL, "R9", "request duration", req_age, TRIES * POLL);
      else
        chk(cs_lo_age >= BIT, "R10", "req release after cs low", cs_lo_age, BIT);
    end
    req_age = req ? req_age + 1 : 0;
    if (word_valid) begin
      if (expw.size() == 0) chk(0, "R5", "unexpected word", word_data, 0);
      else begin
        ew = expw.pop_front();
        chk(word_data == ew, (gmode == 2) ? "R9" : "R5", "word data", word_data, ew);
        got++;
      end
    end
    if (done) chk(!busy, "R12", "busy at done", busy, 0);
    gnt = (gmode == 0) || (gmode == 1 && req && req_age > gdelay);
    psk = ee_sk; pcs = ee_cs; pdi = ee_di; preq = req;
  end

  task automatic run(input logic [7:0] b, input int n, input bit hs, input bit big,
                     input int gm, input int gd, input bit poke);
    logic [7:0] a;
    cur_hs = hs; cur_big = big; gmode = gm; gdelay = gd; got = 0;
    for (int i = 0; i < n; i++) begin
      a = 8'(b + i);
      if (!big) a = a & 8'h3F;
      if (gm != 2) expa.push_back(a);
      expw.push_back(gm == 2 ? 16'hFFFF : memf(a));
    end
    @(negedge clk);
    base_addr = b; word_cnt = 8'(n); hs_en = hs; size_big = big; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R12", "busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      base_addr = 8'h11; word_cnt = 8'd5; size_big = ~big; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && !timed_out) @(negedge clk);
    chk(got == n, "R12", "words per run", got, n);
    chk(expw.size() == 0 && expa.size() == 0, "R5", "words left over", expw.size(), 0);
    @(negedge clk);
    chk(!done && !busy, "R12", "done one cycle", {done, busy}, 0);
    expw.delete(); expa.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, req, busy, done, word_valid} == 7'b0, "R1", "reset outputs",
        {ee_cs, ee_sk, ee_di, req, busy, done, word_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(8'h05, 4, 0, 0, 0, 0, 0);
    run(8'hA7, 3, 0, 1, 0, 0, 0);
    run(8'd62, 3, 0, 0, 0, 0, 0);
    run(8'd254, 3, 0, 1, 0, 0, 0);
    run(8'h30, 2, 1, 0, 0, 0, 0);
    run(8'h81, 2, 1, 1, 1, 37, 0);
    run(8'h10, 2, 1, 1, 2, 0, 0);
    run(8'h20, 3, 1, 0, 1, 5, 1);
    run(8'h00, 0, 0, 0, 0, 0, 0);
    run(8'h3F, 2, 0, 1, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      timed_out = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule